// File: doc/BRIEF.md
# Memory-Map and Interrupt-Mode Option Register

This block is one configuration register on a small microcontroller's byte bus. Two of its bits decide whether each of two fixed address windows is served by RAM or by ROM. For whatever address is on the bus, the block drives a RAM select and a ROM select for those windows. A third bit chooses how the external interrupt line is qualified. The interrupt line is active low and asynchronous. The block synchronises it, finds falling edges, and drives an interrupt request toward the CPU.

The mode bit can be written only once. After reset the first write to the register takes its value, and a sticky lock then keeps it for the rest of the run. The window bits stay writable at all times. In edge-only mode a falling edge latches a request that holds until an acknowledge clears it. In edge-and-level mode, a line that stays low also keeps the request asserted, whatever the latch holds.

Top module: `mem_option_ctl`

## Requirements
- R1: After reset, a read at 0x3FDF returns 0x02: both window bits are cleared and the mode bit is set. Both windows then select ROM.
- R2: A read at 0x3FDF returns bit 7 = window-A RAM select, bit 6 = window-B RAM select, bit 1 = interrupt mode, and 0 in bits 5..2 and bit 0. A read at any other address returns 0x00.
- R3: Every write to 0x3FDF loads bits 7 and 6 from write-data bits 7 and 6, including writes after the first.
- R4: Only the first write to 0x3FDF after reset loads the mode bit from write-data bit 1. Later writes leave it unchanged.
- R5: For bus addresses 0x0020..0x004F, ram_sel equals bit 7 and rom_sel equals its inverse.
- R6: For bus addresses 0x0100..0x017F, ram_sel equals bit 6 and rom_sel equals its inverse.
- R7: Outside both windows, ram_sel and rom_sel are both 0, and the two are never high together.
- R8: A write to any address other than 0x3FDF has no effect on the register.
- R9: A falling edge on irq_pin_n, once it has passed the two-flop synchroniser, sets a latched request. irq_req rises on the third rising clock edge after the pin falls, and stays high until acknowledged.
- R10: irq_ack high at a rising edge clears the latched request. If a new edge is detected at that same edge, the request stays set.
- R11: With the mode bit at 1, irq_req is high while the synchronised pin is low, even after an acknowledge; it rises on the second rising edge after the pin falls. With the mode bit at 0, a pin held low does not bring the request back after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and register |
| ram_sel | output | 1 | Current address falls in a window mapped to RAM |
| rom_sel | output | 1 | Current address falls in a window mapped to ROM |
| irq_pin_n | input | 1 | Asynchronous active-low external interrupt |
| irq_ack | input | 1 | Clears the latched interrupt request |
| irq_req | output | 1 | Qualified interrupt request |

## Verification
The latch set by a newly detected falling edge and the clear from an acknowledge can land on the same clock edge. The bench provokes this by dropping the pin and raising irq_ack exactly in the cycle before the edge on which the synchronised fall is registered. It then expects irq_req to still be high afterwards, and a second lone acknowledge to clear it. A second pairing is the mode bit against a held-low pin: the bench acknowledges while the pin stays low, once in each mode, and expects the request to persist only in edge-and-level mode.

// File: rtl/optreg_pkg.sv
`timescale 1ns/1ps
package optreg_pkg;

    // Register contents plus the write-once lock flag
    typedef struct packed {
        logic win_a_ram;   // window A served by RAM
        logic win_b_ram;   // window B served by RAM
        logic irq_level;   // 1: edge and level qualified interrupt
        logic locked;      // mode bit frozen after first write
    } opt_state_t;

    localparam opt_state_t OPT_RESET = '{
        win_a_ram: 1'b0,
        win_b_ram: 1'b0,
        irq_level: 1'b1,
        locked:    1'b0
    };

endpackage

// File: rtl/optreg_store.sv
`timescale 1ns/1ps
module optreg_store
    import optreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BIT_A  = 7,
    parameter int BIT_B  = 6,
    parameter int BIT_M  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] wdata,
    output opt_state_t        state,
    output logic [DATA_W-1:0] rdata
);

    opt_state_t st_d, st_q;

    // only three data bits are stored; the rest of the bus is don't-care
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.win_a_ram = wdata[BIT_A];
            st_d.win_b_ram = wdata[BIT_B];
            if (!st_q.locked) begin
                st_d.irq_level = wdata[BIT_M];
            end
            st_d.locked = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            rdata[BIT_A] = st_q.win_a_ram;
            rdata[BIT_B] = st_q.win_b_ram;
            rdata[BIT_M] = st_q.irq_level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= OPT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/win_decode.sv
`timescale 1ns/1ps
module win_decode #(
    parameter int ADDR_W  = 16,
    parameter int NUM_WIN = 2,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE = {16'h0100, 16'h0020},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LAST = {16'h017F, 16'h004F}
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_WIN-1:0] win_is_ram,
    output logic               ram_sel,
    output logic               rom_sel
);

    logic [NUM_WIN-1:0] hit_d;
    logic [NUM_WIN-1:0] ram_d;
    logic [NUM_WIN-1:0] rom_d;

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        always_comb begin
            hit_d[gi] = (addr >= WIN_BASE[gi]) && (addr <= WIN_LAST[gi]);
            ram_d[gi] = hit_d[gi] &  win_is_ram[gi];
            rom_d[gi] = hit_d[gi] & ~win_is_ram[gi];
        end
    end

    always_comb begin
        ram_sel = |ram_d;
        rom_sel = |rom_d;
    end

endmodule

// File: rtl/irq_qualifier.sv
`timescale 1ns/1ps
module irq_qualifier #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic ack,
    input  logic level_mode,
    output logic req,
    output logic pin_low_sync,
    output logic latch_out
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
        logic                   latch;
    } qual_t;

    localparam qual_t QUAL_RESET = '{
        chain: '1,
        prev:  1'b1,
        latch: 1'b0
    };

    qual_t q_d, q_q;
    logic  synced;
    logic  fall_d;

    always_comb begin
        synced     = q_q.chain[SYNC_STAGES-1];
        fall_d     = q_q.prev & ~synced;
        q_d        = q_q;
        q_d.chain  = {q_q.chain[SYNC_STAGES-2:0], pin_n};
        q_d.prev   = synced;
        // a fresh edge wins over a simultaneous acknowledge
        q_d.latch  = fall_d | (q_q.latch & ~ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= QUAL_RESET;
        end else begin
            q_q <= q_d;
        end
    end

    always_comb begin
        req          = q_q.latch | (level_mode & ~synced);
        pin_low_sync = ~synced;
        latch_out    = q_q.latch;
    end

endmodule

// File: rtl/mem_option_ctl.sv
`timescale 1ns/1ps
module mem_option_ctl
    import optreg_pkg::*;
#(
    parameter int               ADDR_W      = 16,
    parameter int               DATA_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR   = 16'h3FDF,
    parameter logic [ADDR_W-1:0] WIN_A_BASE = 16'h0020,
    parameter logic [ADDR_W-1:0] WIN_A_LAST = 16'h004F,
    parameter logic [ADDR_W-1:0] WIN_B_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] WIN_B_LAST = 16'h017F,
    parameter int               BIT_A       = 7,
    parameter int               BIT_B       = 6,
    parameter int               BIT_M       = 1,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ram_sel,
    output logic              rom_sel,
    input  logic              irq_pin_n,
    input  logic              irq_ack,
    output logic              irq_req
);

    localparam int NUM_WIN = 2;

    opt_state_t         opt_q;
    logic               reg_hit;
    logic               wr_hit;
    logic [NUM_WIN-1:0] win_is_ram;
    logic               opt_win_a;
    logic               opt_win_b;
    logic               opt_lvl;
    logic               opt_locked;
    logic               pin_low_sync;
    logic               req_latch;

    always_comb begin
        reg_hit    = (bus_addr == REG_ADDR);
        wr_hit     = reg_hit & bus_wr;
        win_is_ram = {opt_q.win_b_ram, opt_q.win_a_ram};
        opt_win_a  = opt_q.win_a_ram;
        opt_win_b  = opt_q.win_b_ram;
        opt_lvl    = opt_q.irq_level;
        opt_locked = opt_q.locked;
    end

    optreg_store #(
        .DATA_W (DATA_W),
        .BIT_A  (BIT_A),
        .BIT_B  (BIT_B),
        .BIT_M  (BIT_M)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .rd_hit (reg_hit),
        .wdata  (bus_wdata),
        .state  (opt_q),
        .rdata  (bus_rdata)
    );

    win_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WIN  (NUM_WIN),
        .WIN_BASE ({WIN_B_BASE, WIN_A_BASE}),
        .WIN_LAST ({WIN_B_LAST, WIN_A_LAST})
    ) u_decode (
        .addr       (bus_addr),
        .win_is_ram (win_is_ram),
        .ram_sel    (ram_sel),
        .rom_sel    (rom_sel)
    );

    irq_qualifier #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_n        (irq_pin_n),
        .ack          (irq_ack),
        .level_mode   (opt_q.irq_level),
        .req          (irq_req),
        .pin_low_sync (pin_low_sync),
        .latch_out    (req_latch)
    );

endmodule

// File: rtl/mem_option_chk.sv
`timescale 1ns/1ps
module mem_option_chk #(
    parameter int               ADDR_W     = 16,
    parameter int               DATA_W     = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR   = 16'h3FDF,
    parameter logic [ADDR_W-1:0] WIN_A_BASE = 16'h0020,
    parameter logic [ADDR_W-1:0] WIN_A_LAST = 16'h004F,
    parameter logic [ADDR_W-1:0] WIN_B_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] WIN_B_LAST = 16'h017F,
    parameter logic [DATA_W-1:0] IMPL_MASK  = 8'hC2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              wd_a,
    input logic              wd_b,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ram_sel,
    input logic              rom_sel,
    input logic              irq_ack,
    input logic              irq_req,
    input logic              win_a,
    input logic              win_b,
    input logic              lvl_mode,
    input logic              locked,
    input logic              pin_low_sync,
    input logic              req_latch
);

    logic in_a, in_b, reg_wr;
    always_comb begin
        in_a   = (bus_addr >= WIN_A_BASE) && (bus_addr <= WIN_A_LAST);
        in_b   = (bus_addr >= WIN_B_BASE) && (bus_addr <= WIN_B_LAST);
        reg_wr = bus_wr && (bus_addr == REG_ADDR);
    end

    AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |-> (bus_rdata == '0)); // R2
    AST_RD_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~IMPL_MASK) == '0)); // R2
    AST_WIN_BITS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (win_a == $past(wd_a)) && (win_b == $past(wd_b))); // R3
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && locked) |=> $stable(lvl_mode)); // R4
    AST_WIN_A_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        in_a |-> (ram_sel == win_a) && (rom_sel == !win_a)); // R5
    AST_WIN_B_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        in_b |-> (ram_sel == win_b) && (rom_sel == !win_b)); // R6
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_sel && rom_sel)); // R7
    AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel || rom_sel) |-> (in_a || in_b)); // R7
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_latch && !irq_ack) |=> req_latch); // R9
    AST_LATCH_DRIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_latch |-> irq_req); // R9
    AST_LEVEL_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode && pin_low_sync) |-> irq_req); // R11

endmodule

bind mem_option_ctl mem_option_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REG_ADDR   (REG_ADDR),
    .WIN_A_BASE (WIN_A_BASE),
    .WIN_A_LAST (WIN_A_LAST),
    .WIN_B_BASE (WIN_B_BASE),
    .WIN_B_LAST (WIN_B_LAST)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .wd_a         (bus_wdata[BIT_A]),
    .wd_b         (bus_wdata[BIT_B]),
    .bus_rdata    (bus_rdata),
    .ram_sel      (ram_sel),
    .rom_sel      (rom_sel),
    .irq_ack      (irq_ack),
    .irq_req      (irq_req),
    .win_a        (opt_win_a),
    .win_b        (opt_win_b),
    .lvl_mode     (opt_lvl),
    .locked       (opt_locked),
    .pin_low_sync (pin_low_sync),
    .req_latch    (req_latch)
);

// File: tb/test_mem_option_ctl.sv
`timescale 1ns/1ps
module test_mem_option_ctl;

    localparam int SIG_RDATA = 0;
    localparam int SIG_RAM   = 1;
    localparam int SIG_ROM   = 2;
    localparam int SIG_IRQ   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ram_sel, rom_sel;
    logic        irq_pin_n = 1'b1;
    logic        irq_ack = 1'b0;
    logic        irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        int         sig;
        logic [7:0] exp;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    mem_option_ctl i_mem_option_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ram_sel   (ram_sel),
        .rom_sel   (rom_sel),
        .irq_pin_n (irq_pin_n),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req)
    );

    function automatic logic [7:0] observe(int sig);
        case (sig)
            SIG_RDATA: return bus_rdata;
            SIG_RAM:   return {7'd0, ram_sel};
            SIG_ROM:   return {7'd0, rom_sel};
            default:   return {7'd0, irq_req};
        endcase
    endfunction

    // monitor: pops expected items and compares against the live outputs
    initial begin
        forever begin
            wait (sb.size() != 0);
            #1;
            begin
                item_t it;
                logic [7:0] got;
                it  = sb.pop_front();
                got = observe(it.sig);
                n_chk++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic expect_out(string tag, int sig, logic [7:0] e);
        item_t it;
        it.tag = tag;
        it.sig = sig;
        it.exp = e;
        sb.push_back(it);
        #3;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_chk(string tag, logic [15:0] a, logic [7:0] e);
        bus_addr = a;
        expect_out(tag, SIG_RDATA, e);
    endtask

    task automatic win_chk(string tag, logic [15:0] a, logic r, logic o);
        bus_addr = a;
        expect_out(tag, SIG_RAM, {7'd0, r});
        expect_out(tag, SIG_ROM, {7'd0, o});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        read_chk("R1 reset value", 16'h3FDF, 8'h02);
        win_chk("R1 window A is ROM", 16'h0030, 1'b0, 1'b1);
        win_chk("R1 window B is ROM", 16'h0150, 1'b0, 1'b1);
        // R2 other addresses read zero
        read_chk("R2 other address", 16'h3FDE, 8'h00);

        // R2 R3 first write, all ones
        bus_write(16'h3FDF, 8'hFF);
        read_chk("R2 R3 write all ones", 16'h3FDF, 8'hC2);
        // R3 R4 second write clears window bits, mode stays
        bus_write(16'h3FDF, 8'h00);
        read_chk("R3 R4 second write", 16'h3FDF, 8'h02);
        // R8 write elsewhere
        bus_write(16'h3FDE, 8'hC0);
        read_chk("R8 stray write", 16'h3FDF, 8'h02);
        win_chk("R8 windows untouched", 16'h0020, 1'b0, 1'b1);

        // R11 level mode (mode bit is 1)
        irq_pin_n = 1'b0;
        tick(2);
        expect_out("R11 level asserts", SIG_IRQ, 8'h01);
        tick(1);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        expect_out("R11 level after ack", SIG_IRQ, 8'h01);
        irq_pin_n = 1'b1;
        tick(3);
        expect_out("R11 level released", SIG_IRQ, 8'h00);

        // R5 R6 R7 windows
        bus_write(16'h3FDF, 8'h80);
        win_chk("R5 base RAM", 16'h0020, 1'b1, 1'b0);
        win_chk("R5 last RAM", 16'h004F, 1'b1, 1'b0);
        win_chk("R7 above A", 16'h0050, 1'b0, 1'b0);
        win_chk("R7 below A", 16'h001F, 1'b0, 1'b0);
        win_chk("R6 base ROM", 16'h0100, 1'b0, 1'b1);
        bus_write(16'h3FDF, 8'h40);
        win_chk("R6 last RAM", 16'h017F, 1'b1, 1'b0);
        win_chk("R6 base RAM", 16'h0100, 1'b1, 1'b0);
        win_chk("R7 above B", 16'h0180, 1'b0, 1'b0);
        win_chk("R5 back to ROM", 16'h0020, 1'b0, 1'b1);

        // R4 first write after a fresh reset takes the mode bit
        do_reset();
        read_chk("R1 reset again", 16'h3FDF, 8'h02);
        bus_write(16'h3FDF, 8'h00);
        read_chk("R4 first write clears mode", 16'h3FDF, 8'h00);
        bus_write(16'h3FDF, 8'h02);
        read_chk("R4 locked mode", 16'h3FDF, 8'h00);
        bus_write(16'h3FDF, 8'hC2);
        read_chk("R3 R4 window bits still writable", 16'h3FDF, 8'hC0);

        // R9 edge-only mode
        tick(3);
        irq_pin_n = 1'b0;
        tick(2);
        expect_out("R9 not yet after two edges", SIG_IRQ, 8'h00);
        tick(1);
        expect_out("R9 latched on third edge", SIG_IRQ, 8'h01);
        tick(4);
        expect_out("R9 held until ack", SIG_IRQ, 8'h01);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        expect_out("R10 ack clears", SIG_IRQ, 8'h00);
        tick(3);
        expect_out("R11 edge-only ignores held low", SIG_IRQ, 8'h00);

        // R10 edge and ack on the same clock edge
        irq_pin_n = 1'b1;
        tick(3);
        irq_pin_n = 1'b0;
        tick(2);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        expect_out("R10 edge wins over ack", SIG_IRQ, 8'h01);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        expect_out("R10 later ack clears", SIG_IRQ, 8'h00);
        irq_pin_n = 1'b1;

        tick(2);
        wait (sb.size() == 0);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule